// File: doc/BRIEF.md
# USB Device Interrupt Flag Register

This block collects interrupt sources for a USB device controller and presents them to a CPU as one 8-bit status register. Three sticky flags are set by the endpoint logic and by the bus-power pin. One flag is set when an IN token for the transmit endpoint finds no valid data in its FIFO. One is set when a transmitted packet is acknowledged by the host. One is set whenever the VBUS level changes in either direction. A fourth, read-only bit shows the synchronized live VBUS level.

Software clears a flag by writing 0 to its bit position. Bits written as 1 leave their flags as they are, so one write can clear some flags without disturbing the rest. A separate enable register on the same bus masks the flags. The single interrupt request is the OR of every flag whose enable bit is set. The protocol engine, the FIFO and the handshake generation stay outside the block, and only their one-cycle strobes come in.

Top module: `usb_evt_irq_flags`

## Requirements
- R1: After reset the status register (address 0) reads 0x00, the enable register (address 1) reads 0x00 and `irqReq` is 0.
- R2: Status bits 7..4 always read 0 and ignore writes. Enable bits 7..3 always read 0, and only enable bits 2..0 hold the written value.
- R3: Status bit 3 reads the VBUS pin level through a two-flop synchronizer. A pin change made just after a clock edge is visible after the second following rising edge, and not after the first.
- R4: A one-cycle pulse on `evtInNoData` sets status bit 2 at the next rising edge, and the bit stays set until software clears it.
- R5: A one-cycle pulse on `evtTxAck` sets status bit 1 at the next rising edge, and the bit stays set until software clears it.
- R6: A rising or a falling change of the synchronized VBUS level sets status bit 0 one edge after bit 3 changes.
- R7: A write to address 0 clears each of flags 2..0 whose data bit is 0 and leaves unchanged each flag whose data bit is 1.
- R8: When a set event and a clearing write reach the same flag in the same cycle, the flag ends up set.
- R9: `irqReq` is 1 exactly when the AND of status bits 2..0 and enable bits 2..0 is non-zero.
- R10: Reads are combinational and return the register value from before any update at the coming edge. Reading has no effect on any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Register access strobe |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 1 | 0 = status flags, 1 = enable |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for `busAddr` |
| evtInNoData | input | 1 | IN token arrived with the transmit FIFO empty |
| evtTxAck | input | 1 | Transmit packet acknowledged by the host |
| vbusPin | input | 1 | Asynchronous VBUS level |
| irqReq | output | 1 | Interrupt request |

## Verification
A software clearing write and a hardware set event can land on the same flag in the same cycle. The bench provokes this for each flag. For the two strobe flags it drives the write and the strobe together. For the connect flag it times a clearing write to reach the edge at which the VBUS change is detected. In every case the flag must read back as set. In the exhaustive sweep of clear masks over all flag patterns, the expected read-back is computed as the AND of the loaded pattern and the written data.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
  localparam int REG_W    = 8;
  localparam int FLAG_N   = 3;
  localparam int STAT_BIT = 3;

  localparam int FLAG_CONN   = 0;
  localparam int FLAG_TXDONE = 1;
  localparam int FLAG_TXREQ  = 2;

  localparam logic ADDR_FLAGS  = 1'b0;
  localparam logic ADDR_ENABLE = 1'b1;

  typedef struct packed {
    logic             clrFlags;
    logic             loadEnable;
    logic [REG_W-1:0] data;
  } ctlStrobe_t;
endpackage

// File: rtl/usb_irq_ctl.sv
module usb_irq_ctl
  import usb_irq_pkg::*;
(
  input  logic             busSel,
  input  logic             busWr,
  input  logic             busAddr,
  input  logic [REG_W-1:0] busWdata,
  output ctlStrobe_t       strobe
);
  logic wrAccess;

  always_comb begin
    wrAccess          = busSel && busWr;
    strobe.clrFlags   = wrAccess && (busAddr == ADDR_FLAGS);
    strobe.loadEnable = wrAccess && (busAddr == ADDR_ENABLE);
    strobe.data       = busWdata;
  end
endmodule

// File: rtl/usb_irq_datapath.sv
module usb_irq_datapath
  import usb_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       strobe,
  input  logic             busAddr,
  input  logic             evtInNoData,
  input  logic             evtTxAck,
  input  logic             vbusPin,
  output logic [REG_W-1:0] rdata,
  output logic             irqReq
);
  localparam int PAD_W = REG_W - FLAG_N - 1;
  localparam int EN_PAD_W = REG_W - FLAG_N;

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   vbusLive;
  logic                   vbusPrev;
  logic [FLAG_N-1:0]      flags;
  logic [FLAG_N-1:0]      enable;
  logic [FLAG_N-1:0]      setMask;
  logic [FLAG_N-1:0]      clrMask;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncChain <= '0;
      vbusPrev  <= 1'b0;
    end else begin
      syncChain <= {syncChain[SYNC_STAGES-2:0], vbusPin};
      vbusPrev  <= vbusLive;
    end
  end

  assign vbusLive = syncChain[SYNC_STAGES-1];

  always_comb begin
    setMask              = '0;
    setMask[FLAG_CONN]   = vbusLive ^ vbusPrev;
    setMask[FLAG_TXDONE] = evtTxAck;
    setMask[FLAG_TXREQ]  = evtInNoData;
    clrMask = strobe.clrFlags ? ~strobe.data[FLAG_N-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flags  <= '0;
      enable <= '0;
    end else begin
      flags <= (flags & ~clrMask) | setMask;
      if (strobe.loadEnable)
        enable <= strobe.data[FLAG_N-1:0];
    end
  end

  always_comb begin
    if (busAddr == ADDR_ENABLE)
      rdata = {{EN_PAD_W{1'b0}}, enable};
    else
      rdata = {{PAD_W{1'b0}}, vbusLive, flags};
  end

  assign irqReq = |(flags & enable);

  // R3: the status bit follows the first synchronizer stage one edge later
  a_r3_sync_delay: assert property (@(posedge clk) disable iff (!rstN)
    vbusLive == $past(syncChain[SYNC_STAGES-2]));

  // R6: any change of the synchronized level leaves the connect flag set
  a_r6_edge_sets_conn: assert property (@(posedge clk) disable iff (!rstN)
    (vbusLive != vbusPrev) |=> flags[FLAG_CONN]);

  // R8: the transfer-request strobe always wins over a clearing write
  a_r8_set_wins_txreq: assert property (@(posedge clk) disable iff (!rstN)
    evtInNoData |=> flags[FLAG_TXREQ]);

  // R5: the acknowledge strobe sets its flag
  a_r5_txack_sets: assert property (@(posedge clk) disable iff (!rstN)
    evtTxAck |=> flags[FLAG_TXDONE]);

  // R7: a zero data bit with no competing event clears the flag
  a_r7_clear_txreq: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clrFlags && !strobe.data[FLAG_TXREQ] && !evtInNoData)
      |=> !flags[FLAG_TXREQ]);

  // R7: without a write or an event a flag holds its value
  a_r7_hold_txdone: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.clrFlags && !evtTxAck) |=> $stable(flags[FLAG_TXDONE]));
endmodule

// File: rtl/usb_evt_irq_flags.sv
module usb_evt_irq_flags
  import usb_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busSel,
  input  logic             busWr,
  input  logic             busAddr,
  input  logic [REG_W-1:0] busWdata,
  output logic [REG_W-1:0] busRdata,
  input  logic             evtInNoData,
  input  logic             evtTxAck,
  input  logic             vbusPin,
  output logic             irqReq
);
  ctlStrobe_t strobe;

  usb_irq_ctl u_ctl (
    .busSel   (busSel),
    .busWr    (busWr),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .strobe   (strobe)
  );

  usb_irq_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .busAddr     (busAddr),
    .evtInNoData (evtInNoData),
    .evtTxAck    (evtTxAck),
    .vbusPin     (vbusPin),
    .rdata       (busRdata),
    .irqReq      (irqReq)
  );

  // R2: the reserved upper status bits never read as 1
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    busRdata[REG_W-1:STAT_BIT+1] == '0);

  // R9: writing an all-zero enable silences the request
  a_r9_enable_off: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWr && busAddr == ADDR_ENABLE && busWdata[FLAG_N-1:0] == '0)
      |=> !irqReq);
endmodule

// File: tb/usb_evt_irq_flags_tb.sv
module usb_evt_irq_flags_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 150000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busSel = 1'b0;
  logic       busWr = 1'b0;
  logic       busAddr = 1'b0;
  logic [7:0] busWdata = 8'h00;
  logic [7:0] busRdata;
  logic       evtInNoData = 1'b0;
  logic       evtTxAck = 1'b0;
  logic       vbusPin = 1'b0;
  logic       irqReq;

  int  total = 0;
  int  bad = 0;
  bit  done = 1'b0;
  logic vbusLevel = 1'b0;

  usb_evt_irq_flags u_dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .evtInNoData(evtInNoData), .evtTxAck(evtTxAck),
    .vbusPin(vbusPin), .irqReq(irqReq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic rd(input logic addr, output logic [7:0] val);
    busAddr = addr;
    #1;
    val = busRdata;
  endtask

  task automatic wr(input logic addr, input logic [7:0] data);
    busSel = 1'b1; busWr = 1'b1; busAddr = addr; busWdata = data;
    tick();
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic toggleVbus();
    vbusPin = ~vbusPin;
    vbusLevel = ~vbusLevel;
    tick(); tick(); tick();
  endtask

  task automatic loadFlags(input logic [2:0] m);
    wr(1'b0, 8'h00);
    if (m[2]) begin evtInNoData = 1'b1; tick(); evtInNoData = 1'b0; end
    if (m[1]) begin evtTxAck = 1'b1; tick(); evtTxAck = 1'b0; end
    if (m[0]) toggleVbus();
  endtask

  initial begin
    repeat (MAX_CYCLES) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [7:0] v2;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    rd(1'b0, v); check("R1 status", v, 8'h00);
    rd(1'b1, v); check("R1 enable", v, 8'h00);
    check("R1 irq", irqReq, 1'b0);

    // R4 sticky transfer request
    evtInNoData = 1'b1; tick(); evtInNoData = 1'b0;
    rd(1'b0, v); check("R4 set", v, 8'h04);
    repeat (5) tick();
    rd(1'b0, v); check("R4 sticky", v, 8'h04);
    wr(1'b0, 8'h00);

    // R5 sticky transmit complete
    evtTxAck = 1'b1; tick(); evtTxAck = 1'b0;
    rd(1'b0, v); check("R5 set", v, 8'h02);
    repeat (5) tick();
    rd(1'b0, v); check("R5 sticky", v, 8'h02);
    wr(1'b0, 8'h00);

    // R3 / R6 timing on a rising then a falling VBUS change
    for (int k = 0; k < 2; k++) begin
      vbusPin = ~vbusPin; vbusLevel = ~vbusLevel;
      tick();
      rd(1'b0, v); check("R3 not yet", v, {4'h0, ~vbusLevel, 3'b000});
      tick();
      rd(1'b0, v); check("R3 visible", v, {4'h0, vbusLevel, 3'b000});
      check("R6 not yet", v[0], 1'b0);
      tick();
      rd(1'b0, v); check("R6 set", v, {4'h0, vbusLevel, 3'b001});
      wr(1'b0, 8'hFE);
      rd(1'b0, v); check("R7 clear conn", v, {4'h0, vbusLevel, 3'b000});
    end

    // R7 and R2: every clear pattern against every flag pattern
    for (int m = 0; m < 8; m++) begin
      for (int w = 0; w < 256; w++) begin
        loadFlags(m[2:0]);
        wr(1'b0, w[7:0]);
        rd(1'b0, v);
        check("R7 R2 sweep", v, {4'h0, vbusLevel, m[2:0] & w[2:0]});
      end
    end

    // R8 set wins over clear in the same cycle
    wr(1'b0, 8'h00);
    busSel = 1'b1; busWr = 1'b1; busAddr = 1'b0; busWdata = 8'h00;
    evtInNoData = 1'b1; evtTxAck = 1'b1;
    tick();
    busSel = 1'b0; busWr = 1'b0; evtInNoData = 1'b0; evtTxAck = 1'b0;
    rd(1'b0, v); check("R8 strobe flags", v, {4'h0, vbusLevel, 3'b110});
    wr(1'b0, 8'h00);
    vbusPin = ~vbusPin; vbusLevel = ~vbusLevel;
    tick(); tick();
    wr(1'b0, 8'h00);
    rd(1'b0, v); check("R8 conn flag", v, {4'h0, vbusLevel, 3'b001});

    // R2 enable read-back over every value
    for (int e = 0; e < 256; e++) begin
      wr(1'b1, e[7:0]);
      rd(1'b1, v); check("R2 enable", v, {5'h00, e[2:0]});
    end

    // R9 request over every enable and flag combination
    for (int e = 0; e < 8; e++) begin
      for (int m = 0; m < 8; m++) begin
        wr(1'b1, e[7:0]);
        loadFlags(m[2:0]);
        check("R9 irq", irqReq, |(e[2:0] & m[2:0]));
      end
    end

    // R10 read returns pre-update value, reads have no side effect
    wr(1'b1, 8'h00);
    wr(1'b0, 8'h00);
    evtInNoData = 1'b1;
    rd(1'b0, v); check("R10 old value", v, {4'h0, vbusLevel, 3'b000});
    tick();
    evtInNoData = 1'b0;
    busSel = 1'b1; busWr = 1'b0;
    rd(1'b0, v); tick(); rd(1'b0, v2);
    busSel = 1'b0;
    check("R10 first read", v, {4'h0, vbusLevel, 3'b100});
    check("R10 no side effect", v2, {4'h0, vbusLevel, 3'b100});

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule